// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits on the host write path of a byte-wide non-volatile memory. Every host write, an address and a data byte, passes through it. It watches these writes for two fixed command sequences, one that turns software protection on and one that turns it off, and keeps a persistent protection flag. For each write it gives a verdict in the same cycle. The write is either consumed as a command step, allowed on to the page buffer, or blocked. A blocked write stores nothing but still starts a dummy write period.

A sequence that completes opens a load window. Writes in that window reach the page buffer. The new protection value is taken up when the external write timer reports the end of the period. Because the enable sequence also opens the window, a protected host puts the enable sequence in front of each page write it wants stored. The page buffer and the timer lie outside the block. They are reached through `verdict`, `timerStart` and `periodDone`.

Top module: `wprot_sequencer`

## Requirements
- R1: After reset `protOn` is 0. In any cycle with `wrValid` low, `verdict` is 0 (none) and `timerStart` is 0.
- R2: The enable sequence is three writes: data AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h. Each of these writes has verdict 1 (command). The last of them pulses `timerStart` in the same cycle.
- R3: A completed sequence opens a load window. In the window every write has verdict 2 (pass) and `timerStart` low, even if it looks like a command step. When `periodDone` is high in a cycle where the window is open, the window closes. From the next cycle, `protOn` shows the value the sequence selected: 1 for enable, 0 for disable. This happens even if no data was loaded.
- R4: The disable sequence is six writes: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 20h to 5555h. Each step has verdict 1. The last step pulses `timerStart` and opens the window.
- R5: With `protOn` 1 and no window open, a write that is not a command step has verdict 3 (blocked) and pulses `timerStart` in the same cycle. `protOn` is unchanged.
- R6: With `protOn` 0 and no window open, a write that is not a command step has verdict 2 (pass) and `timerStart` low.
- R7: A write that does not match the next expected step drops the partial sequence. It is then judged as if no sequence were in progress: AAh to 5555h starts a new sequence, and any other write is an ordinary write.
- R8: Address matching uses only address bits 14:0. Bit 15 is ignored.
- R9: `periodDone` has no effect on `protOn` while no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A host write is present this cycle |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data byte |
| periodDone | input | 1 | End of the current write period, from the external timer |
| verdict | output | 2 | 0 none, 1 command, 2 pass, 3 blocked |
| timerStart | output | 1 | Start a write period |
| protOn | output | 1 | Software protection active |

## Verification
Four properties are checked on every cycle. A verdict appears exactly when a write is present. A blocked verdict occurs only while protected. A timer start comes only with a command or a blocked write. The protection flag changes only on the cycle after an end-of-period. Whether a given sequence of writes is recognised in the right order, how a broken sequence restarts, how address bit 15 is masked, and how the load window behaves can only be shown by the bench's scenarios. The bench checks these against its own history-based model.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_CMD   = 2'd1,
    V_PASS  = 2'd2,
    V_BLOCK = 2'd3
  } verdict_t;

  // pattern hits decoded from the current write
  typedef struct packed {
    logic seqA;    // AA to 5555
    logic seqB;    // 55 to 2AAA
    logic enFin;   // A0 to 5555
    logic disMid;  // 80 to 5555
    logic disFin;  // 20 to 5555
  } hits_t;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;
    logic target;
  } strobes_t;
endpackage

// File: rtl/wprot_path.sv
module wprot_path
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CMP_BITS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              periodDone,
  input  strobes_t          strobes,
  output hits_t             hits,
  output logic              protOn,
  output logic              winOpen
);
  localparam logic [CMP_BITS-1:0] ADDR_HI = CMP_BITS'(16'h5555);
  localparam logic [CMP_BITS-1:0] ADDR_LO = CMP_BITS'(16'h2AAA);

  logic [CMP_BITS-1:0] cmpAddr;
  logic                atHi, atLo;
  logic                tgtQ;

  assign cmpAddr = wrAddr[CMP_BITS-1:0];
  assign atHi    = (cmpAddr == ADDR_HI);
  assign atLo    = (cmpAddr == ADDR_LO);

  always_comb begin
    hits.seqA   = atHi && (wrData == DATA_W'(8'hAA));
    hits.seqB   = atLo && (wrData == DATA_W'(8'h55));
    hits.enFin  = atHi && (wrData == DATA_W'(8'hA0));
    hits.disMid = atHi && (wrData == DATA_W'(8'h80));
    hits.disFin = atHi && (wrData == DATA_W'(8'h20));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOn  <= 1'b0;
      winOpen <= 1'b0;
      tgtQ    <= 1'b0;
    end else if (strobes.openWin) begin
      winOpen <= 1'b1;
      tgtQ    <= strobes.target;
    end else if (periodDone && winOpen) begin
      winOpen <= 1'b0;
      protOn  <= tgtQ;
    end
  end

  // R3 R9
  prot_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protOn != $past(protOn)) |-> $past(periodDone));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrValid,
  input  hits_t    hits,
  input  logic     protOn,
  input  logic     winOpen,
  output strobes_t strobes,
  output verdict_t verdict,
  output logic     timerStart
);
  typedef enum logic [2:0] {IDLE, S1, S2, S3, S4, S5} step_t;

  step_t st, nextSt;
  logic  matched;

  always_comb begin
    verdict    = V_NONE;
    timerStart = 1'b0;
    strobes    = '0;
    nextSt     = st;
    matched    = 1'b0;
    if (wrValid) begin
      nextSt = IDLE;
      if (winOpen) begin
        verdict = V_PASS;
      end else begin
        case (st)
          S1: if (hits.seqB) begin matched = 1'b1; nextSt = S2; end
          S2: begin
            if (hits.enFin) begin
              matched = 1'b1;
              timerStart = 1'b1;
              strobes.openWin = 1'b1;
              strobes.target = 1'b1;
            end else if (hits.disMid) begin
              matched = 1'b1;
              nextSt = S3;
            end
          end
          S3: if (hits.seqA) begin matched = 1'b1; nextSt = S4; end
          S4: if (hits.seqB) begin matched = 1'b1; nextSt = S5; end
          S5: begin
            if (hits.disFin) begin
              matched = 1'b1;
              timerStart = 1'b1;
              strobes.openWin = 1'b1;
              strobes.target = 1'b0;
            end
          end
          default: matched = 1'b0;
        endcase
        if (matched) begin
          verdict = V_CMD;
        end else if (hits.seqA) begin
          verdict = V_CMD;
          nextSt = S1;
        end else begin
          verdict = protOn ? V_BLOCK : V_PASS;
          timerStart = protOn;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= IDLE;
    else       st <= nextSt;
  end

  // R1
  verdict_iff_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdict != V_NONE) == wrValid);

  // R5
  block_needs_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == V_BLOCK) |-> protOn);

  // R2
  timer_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerStart |-> (verdict == V_CMD || verdict == V_BLOCK));
endmodule

// File: rtl/wprot_sequencer.sv
module wprot_sequencer
  import wprot_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CMP_BITS = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              periodDone,
  output logic [1:0]        verdict,
  output logic              timerStart,
  output logic              protOn
);
  hits_t    hits;
  strobes_t strobes;
  verdict_t verdictE;
  logic     winOpen;

  wprot_path #(.ADDR_W(ADDR_W), .DATA_W(8), .CMP_BITS(CMP_BITS)) i_path (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .periodDone(periodDone), .strobes(strobes), .hits(hits),
    .protOn(protOn), .winOpen(winOpen)
  );

  wprot_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .hits(hits),
    .protOn(protOn), .winOpen(winOpen), .strobes(strobes),
    .verdict(verdictE), .timerStart(timerStart)
  );

  assign verdict = verdictE;
endmodule

// File: tb/test_wprot_sequencer.sv
module test_wprot_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        periodDone = 1'b0;
  logic [1:0]  verdict;
  logic        timerStart;
  logic        protOn;

  int vectors = 0;
  int errors = 0;

  // model state
  int  hist[$];
  bit  mWin = 0, mTgt = 0, mProt = 0;
  int  enSeq[3]  = '{32'h5555AA, 32'h2AAA55, 32'h5555A0};
  int  disSeq[6] = '{32'h5555AA, 32'h2AAA55, 32'h555580,
                     32'h5555AA, 32'h2AAA55, 32'h555520};

  always #4 clk = ~clk;

  wprot_sequencer i_wprot_sequencer (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .periodDone(periodDone), .verdict(verdict),
    .timerStart(timerStart), .protOn(protOn)
  );

  function automatic bit isPrefix(int cand[$], bit useEn);
    int n = useEn ? 3 : 6;
    if (cand.size() > n) return 0;
    foreach (cand[i]) begin
      if (useEn && cand[i] != enSeq[i]) return 0;
      if (!useEn && cand[i] != disSeq[i]) return 0;
    end
    return 1;
  endfunction

  task automatic step(input bit v, input logic [15:0] a, input logic [7:0] d,
                      input bit pd, input string req);
    int expV; bit expT; bit expP; int key; int cand[$]; int one[$];
    @(negedge clk);
    wrValid = v; wrAddr = a; wrData = d; periodDone = pd;
    #2;
    expP = mProt; expV = 0; expT = 0;
    key = {a[14:0], d} & 32'h7FFFFF;
    if (v) begin
      if (mWin) begin
        expV = 2; hist.delete();
      end else begin
        cand = hist; cand.push_back(key);
        one.push_back(key);
        if (cand.size() == 3 && isPrefix(cand, 1)) begin
          expV = 1; expT = 1; mWin = 1; mTgt = 1; hist.delete();
        end else if (cand.size() == 6 && isPrefix(cand, 0)) begin
          expV = 1; expT = 1; mWin = 1; mTgt = 0; hist.delete();
        end else if (isPrefix(cand, 1) || isPrefix(cand, 0)) begin
          expV = 1; hist = cand;
        end else if (isPrefix(one, 1)) begin
          expV = 1; hist = one;
        end else begin
          expV = mProt ? 3 : 2; expT = mProt; hist.delete();
        end
      end
    end
    if (pd && mWin && !(v && expT)) begin
      mWin = 0; mProt = mTgt;
    end
    vectors++;
    if (verdict !== 2'(expV) || timerStart !== expT || protOn !== expP) begin
      errors++;
      $display("FAIL %s: verdict=%0d timerStart=%0b protOn=%0b expected %0d %0b %0b",
               req, verdict, timerStart, protOn, expV, expT, expP);
    end
  endtask

  task automatic enableSeq(input string req);
    step(1, 16'h5555, 8'hAA, 0, req);
    step(1, 16'h2AAA, 8'h55, 0, req);
    step(1, 16'h5555, 8'hA0, 0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(0, 16'h0, 8'h0, 0, "R1");
    step(0, 16'h5555, 8'hAA, 1, "R1");
    // R6 ordinary writes while unprotected
    step(1, 16'h1234, 8'h5A, 0, "R6");
    step(1, 16'h0040, 8'hFF, 0, "R6");
    // R7 broken sequence falls back to ordinary write
    step(1, 16'h5555, 8'hAA, 0, "R7");
    step(1, 16'h2AAA, 8'h11, 0, "R7");
    // R7 mismatch that is itself a first step restarts
    step(1, 16'h5555, 8'hAA, 0, "R7");
    step(1, 16'h5555, 8'hAA, 0, "R7");
    step(1, 16'h2AAA, 8'h55, 0, "R2");
    // R8 bit 15 ignored on the final step
    step(1, 16'hD555, 8'hA0, 0, "R8");
    // R3 window passes data, even command-like data
    step(1, 16'h0100, 8'h01, 0, "R3");
    step(1, 16'h5555, 8'hAA, 0, "R3");
    step(0, 16'h0, 8'h0, 1, "R3");
    step(0, 16'h0, 8'h0, 0, "R3");
    // R5 protected writes blocked
    step(1, 16'h0200, 8'h22, 0, "R5");
    step(1, 16'h2AAA, 8'h55, 0, "R5");
    // R9 stray end-of-period
    step(0, 16'h0, 8'h0, 1, "R9");
    step(0, 16'h0, 8'h0, 0, "R9");
    // R2 prefix lets a protected write through
    enableSeq("R2");
    step(1, 16'h0300, 8'h33, 0, "R3");
    step(0, 16'h0, 8'h0, 1, "R3");
    step(0, 16'h0, 8'h0, 0, "R3");
    // R7 aborted disable at step five
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'h2AAA, 8'h55, 0, "R4");
    step(1, 16'h5555, 8'h80, 0, "R4");
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'h2AAA, 8'h54, 0, "R7");
    // R4 full disable, no data, then period end
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'hAAAA, 8'h55, 0, "R8");
    step(1, 16'h5555, 8'h80, 0, "R4");
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'h2AAA, 8'h55, 0, "R4");
    step(1, 16'h5555, 8'h20, 0, "R4");
    step(0, 16'h0, 8'h0, 0, "R4");
    step(0, 16'h0, 8'h0, 1, "R4");
    step(0, 16'h0, 8'h0, 0, "R4");
    step(1, 16'h0400, 8'h44, 0, "R6");
    // R4 disable while unprotected keeps protOn at 0
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'h2AAA, 8'h55, 0, "R4");
    step(1, 16'h5555, 8'h80, 0, "R4");
    step(1, 16'h5555, 8'hAA, 0, "R4");
    step(1, 16'h2AAA, 8'h55, 0, "R4");
    step(1, 16'h5555, 8'h20, 0, "R4");
    step(0, 16'h0, 8'h0, 1, "R4");
    step(0, 16'h0, 8'h0, 0, "R4");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule